// File: doc/BRIEF.md
# Ethernet Transmit Frame Encapsulator

This block turns a frame body written by a host into a serial Ethernet bit stream. The host writes the body one byte per accepted write. The body is the destination address, source address, length/type and payload, and the host marks the final byte. The bytes collect in a local byte buffer. Once enough of the frame is buffered and the medium-access logic grants the line, the block sends a 7-byte alternating preamble and the start-of-frame delimiter, then the body. It zero-pads short frames and closes with a CRC-32 frame check sequence. A per-frame control can suppress the check sequence.

The start point is selectable. Transmission can begin early, once a small, medium or large byte count is buffered. It can also wait for the whole frame. If the host falls behind during an early start, the frame is aborted with an underrun indication, and the unsent remainder of that frame is discarded once the host delivers it. Bits leave one per clock-enable strobe. Line coding, carrier sensing and retry policy belong to neighbouring blocks.

Top module: `eth_tx_framer`

## Requirements
- R1: Every frame begins with seven bytes 0x55 followed by the delimiter byte 0xD5, all sent least-significant bit first, so the line carries 1,0,1,0,... and ends the delimiter with 1,1.
- R2: Body bytes follow the delimiter in the order written, each sent least-significant bit first, unchanged.
- R3: When the body is shorter than 60 bytes, zero bytes are appended until body plus pad is 60 bytes. Longer bodies get no pad.
- R4: Unless inhibited, four check-sequence bytes follow. They hold the complement of a CRC-32 (polynomial 0x04C11DB7, register preset to all ones) over body and pad, sent least-significant bit first. A receiver running the same CRC over body, pad and check sequence then ends at 0xDEBB20E3.
- R5: With `no_fcs` high when the frame starts, no check sequence is sent; the frame still gets padded to 60 bytes.
- R6: `thr_sel` picks the start condition: 0 starts at 5 buffered bytes, 1 at 381, 2 at 1021, and 3 only when the byte flagged last is buffered. In modes 0 to 2 a completely buffered frame also starts.
- R7: No preamble bit is sent while `grant` is low.
- R8: If the buffer is empty when the next body byte is needed before the last byte was sent, transmission stops after the current byte. `underrun` pulses, no check sequence follows and `done` does not pulse. The rest of that frame is discarded, and the next frame is sent normally.
- R9: A body longer than 1514 bytes is cut after its 1514th byte. The remaining bytes up to the host's last flag are accepted and dropped.
- R10: `done` is a one-clock pulse in the clock where `tx_en` falls after a frame's final bit, one strobe after that bit was driven.
- R11: `txd` and `tx_en` change only on clocks where `bit_en` is high.
- R12: Under reset, and whenever `tx_en` is low, `txd` is low; after reset `done` is low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host write strobe for one body byte |
| wr_data | input | 8 | Body byte |
| wr_last | input | 1 | Marks the final body byte of a frame |
| wr_ready | output | 1 | Write is accepted in this clock |
| thr_sel | input | 2 | Start condition select (see R6) |
| no_fcs | input | 1 | Suppress check sequence for the next frame |
| grant | input | 1 | Medium access permitted |
| bit_en | input | 1 | Bit-rate strobe |
| txd | output | 1 | Serial NRZ transmit data |
| tx_en | output | 1 | High while frame bits are on `txd` |
| done | output | 1 | Frame completed pulse |
| underrun | output | 1 | Frame aborted by buffer starvation pulse |

## Verification
The bench builds the block with its default parameters: a 2048-entry buffer and start counts of 5, 381 and 1021. With that buffer a whole 1514-byte body fits, so the whole-frame mode and the length cut can both be exercised. The largest early-start count can also be held back one byte short of its trigger. A divided strobe reaches the pacing behaviour, and starving the buffer after an early start reaches the abort and discard path.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;

    localparam logic [7:0]  PRE_BYTE   = 8'h55;
    localparam logic [7:0]  SFD_BYTE   = 8'hD5;
    localparam int          PRE_BYTES  = 8;      // seven preamble bytes plus delimiter
    localparam int          MIN_BODY   = 60;     // body + pad, excluding check sequence
    localparam int          MAX_BODY   = 1514;   // body limit, excluding check sequence
    localparam int          FCS_BITS   = 32;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320; // bit-reversed 0x04C11DB7

    typedef enum logic [1:0] {
        THR_SMALL = 2'd0,
        THR_MID   = 2'd1,
        THR_LARGE = 2'd2,
        THR_WHOLE = 2'd3
    } thr_sel_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_BODY,
        S_PAD,
        S_FCS,
        S_END,
        S_DRAIN
    } ser_state_e;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } buf_word_t;

    // One serial step of the reflected CRC-32 register.
    function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return fb ? ({1'b0, c[31:1]} ^ CRC_POLY_R) : {1'b0, c[31:1]};
    endfunction

endpackage

// File: rtl/eth_txf_fifo.sv
module eth_txf_fifo
    import eth_txf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  buf_word_t       din,
    input  logic            pop,
    output buf_word_t       dout,
    output logic            full,
    output logic            empty,
    output logic [CW-1:0]   count
);

    buf_word_t          mem [DEPTH];
    logic [AW-1:0]      wr_ptr;
    logic [AW-1:0]      rd_ptr;
    logic               do_push;
    logic               do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wrap_inc(wr_ptr);
            if (do_pop)  rd_ptr <= wrap_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/eth_txf_admit.sv
module eth_txf_admit
    import eth_txf_pkg::*;
#(
    parameter int BODY_LIMIT = MAX_BODY,
    localparam int LW = $clog2(BODY_LIMIT + 1)
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        wr_last,
    input  logic        fifo_full,
    output logic        wr_ready,
    output logic        push,
    output buf_word_t   push_word
);

    logic [LW-1:0] wcnt;
    logic          dropping;
    logic          accept;
    logic          at_limit;

    assign wr_ready       = dropping || !fifo_full;
    assign accept         = wr_valid && wr_ready;
    assign at_limit       = (wcnt == LW'(BODY_LIMIT - 1));
    assign push           = accept && !dropping;
    assign push_word.data = wr_data;
    assign push_word.last = wr_last || at_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt     <= '0;
            dropping <= 1'b0;
        end else if (accept) begin
            if (dropping) begin
                if (wr_last) dropping <= 1'b0;
            end else if (wr_last) begin
                wcnt <= '0;
            end else if (at_limit) begin
                wcnt     <= '0;
                dropping <= 1'b1;
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/eth_txf_gate.sv
module eth_txf_gate
    import eth_txf_pkg::*;
#(
    parameter int CW    = 12,
    parameter int THR_A = 5,
    parameter int THR_B = 381,
    parameter int THR_C = 1021
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            push_last,
    input  logic            pop_last,
    input  logic [CW-1:0]   count,
    input  logic [1:0]      thr_sel,
    output logic            start_ok
);

    logic [CW-1:0] frames_held;
    logic [CW-1:0] thr_val;
    logic          early_ok;

    always_comb begin
        unique case (thr_sel_e'(thr_sel))
            THR_SMALL: thr_val = CW'(THR_A);
            THR_MID:   thr_val = CW'(THR_B);
            THR_LARGE: thr_val = CW'(THR_C);
            default:   thr_val = '0;
        endcase
    end

    assign early_ok = (thr_sel_e'(thr_sel) != THR_WHOLE) && (count >= thr_val);
    assign start_ok = (frames_held != '0) || early_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            frames_held <= '0;
        end else begin
            case ({push_last, pop_last})
                2'b10:   frames_held <= frames_held + 1'b1;
                2'b01:   frames_held <= frames_held - 1'b1;
                default: frames_held <= frames_held;
            endcase
        end
    end

endmodule

// File: rtl/eth_txf_ser.sv
module eth_txf_ser
    import eth_txf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_en,
    input  logic        grant,
    input  logic        start_ok,
    input  logic        no_fcs,
    input  logic        fifo_empty,
    input  buf_word_t   rd_word,
    output logic        pop,
    output logic        txd,
    output logic        tx_en,
    output logic        done,
    output logic        underrun
);

    localparam int NW = $clog2(MAX_BODY + 1);

    ser_state_e     st;
    logic [7:0]     cur;
    logic           cur_last;
    logic [2:0]     bitcnt;
    logic [NW-1:0]  bytecnt;
    logic [4:0]     fcs_cnt;
    logic [31:0]    crc;
    logic           nofcs_q;
    logic           drained;
    logic           byte_end;
    logic           fetch_pt;

    assign byte_end = bit_en && (bitcnt == 3'd7);
    assign fetch_pt = byte_end &&
                      (((st == S_PRE) && (bytecnt == NW'(PRE_BYTES - 1))) ||
                       ((st == S_BODY) && !cur_last));
    assign pop = (fetch_pt && !fifo_empty) ||
                 ((st == S_DRAIN) && !fifo_empty && !drained);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cur      <= '0;
            cur_last <= 1'b0;
            bitcnt   <= '0;
            bytecnt  <= '0;
            fcs_cnt  <= '0;
            crc      <= '1;
            nofcs_q  <= 1'b0;
            drained  <= 1'b0;
            txd      <= 1'b0;
            tx_en    <= 1'b0;
            done     <= 1'b0;
            underrun <= 1'b0;
        end else begin
            done     <= 1'b0;
            underrun <= 1'b0;
            unique case (st)
                S_IDLE: begin
                    if (start_ok && grant) begin
                        st      <= S_PRE;
                        cur     <= PRE_BYTE;
                        bitcnt  <= '0;
                        bytecnt <= '0;
                        crc     <= '1;
                        nofcs_q <= no_fcs;
                    end
                end
                S_PRE: begin
                    if (bit_en) begin
                        tx_en  <= 1'b1;
                        txd    <= cur[bitcnt];
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) begin
                            if (bytecnt == NW'(PRE_BYTES - 1)) begin
                                bytecnt <= '0;
                                if (fifo_empty) begin
                                    st       <= S_DRAIN;
                                    underrun <= 1'b1;
                                    drained  <= 1'b0;
                                end else begin
                                    cur      <= rd_word.data;
                                    cur_last <= rd_word.last;
                                    st       <= S_BODY;
                                end
                            end else begin
                                bytecnt <= bytecnt + 1'b1;
                                cur     <= (bytecnt == NW'(PRE_BYTES - 2)) ? SFD_BYTE : PRE_BYTE;
                            end
                        end
                    end
                end
                S_BODY, S_PAD: begin
                    if (bit_en) begin
                        txd    <= cur[bitcnt];
                        crc    <= crc_bit(crc, cur[bitcnt]);
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) begin
                            bytecnt <= bytecnt + 1'b1;
                            if ((st == S_BODY) && !cur_last) begin
                                if (fifo_empty) begin
                                    st       <= S_DRAIN;
                                    underrun <= 1'b1;
                                    drained  <= 1'b0;
                                end else begin
                                    cur      <= rd_word.data;
                                    cur_last <= rd_word.last;
                                end
                            end else if ((bytecnt + 1'b1) < NW'(MIN_BODY)) begin
                                st  <= S_PAD;
                                cur <= '0;
                            end else if (nofcs_q) begin
                                st <= S_END;
                            end else begin
                                st      <= S_FCS;
                                fcs_cnt <= '0;
                            end
                        end
                    end
                end
                S_FCS: begin
                    if (bit_en) begin
                        txd     <= ~crc[0];
                        crc     <= {1'b0, crc[31:1]};
                        fcs_cnt <= fcs_cnt + 1'b1;
                        if (fcs_cnt == 5'(FCS_BITS - 1)) st <= S_END;
                    end
                end
                S_END: begin
                    if (bit_en) begin
                        tx_en <= 1'b0;
                        txd   <= 1'b0;
                        done  <= 1'b1;
                        st    <= S_IDLE;
                    end
                end
                S_DRAIN: begin
                    if (bit_en) begin
                        tx_en <= 1'b0;
                        txd   <= 1'b0;
                    end
                    if (pop && rd_word.last) drained <= 1'b1;
                    if (drained && !tx_en) begin
                        st      <= S_IDLE;
                        drained <= 1'b0;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_txf_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int THR_A = 5,
    parameter int THR_B = 381,
    parameter int THR_C = 1021
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        wr_last,
    output logic        wr_ready,
    input  logic [1:0]  thr_sel,
    input  logic        no_fcs,
    input  logic        grant,
    input  logic        bit_en,
    output logic        txd,
    output logic        tx_en,
    output logic        done,
    output logic        underrun
);

    localparam int CW = $clog2(DEPTH) + 1;

    logic           fifo_full;
    logic           fifo_empty;
    logic [CW-1:0]  fifo_count;
    logic           push;
    logic           pop;
    buf_word_t      push_word;
    buf_word_t      rd_word;
    logic           start_ok;

    eth_txf_admit #(.BODY_LIMIT(MAX_BODY)) u_admit (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_last   (wr_last),
        .fifo_full (fifo_full),
        .wr_ready  (wr_ready),
        .push      (push),
        .push_word (push_word)
    );

    eth_txf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (push_word),
        .pop   (pop),
        .dout  (rd_word),
        .full  (fifo_full),
        .empty (fifo_empty),
        .count (fifo_count)
    );

    eth_txf_gate #(.CW(CW), .THR_A(THR_A), .THR_B(THR_B), .THR_C(THR_C)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .push_last (push && push_word.last),
        .pop_last  (pop && rd_word.last),
        .count     (fifo_count),
        .thr_sel   (thr_sel),
        .start_ok  (start_ok)
    );

    eth_txf_ser u_ser (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .grant      (grant),
        .start_ok   (start_ok),
        .no_fcs     (no_fcs),
        .fifo_empty (fifo_empty),
        .rd_word    (rd_word),
        .pop        (pop),
        .txd        (txd),
        .tx_en      (tx_en),
        .done       (done),
        .underrun   (underrun)
    );

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic txd,
    input logic tx_en,
    input logic done,
    input logic underrun
);

    AST_PACED_BY_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(txd) && $stable(tx_en))); // R11

    AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        done |-> (!tx_en && $past(tx_en))); // R10

    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_ABORT_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        !(done && underrun)); // R8

    AST_LINE_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> !txd); // R12

endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .txd      (txd),
    .tx_en    (tx_en),
    .done     (done),
    .underrun (underrun)
);

// File: tb/sim_eth_tx_framer.sv
`timescale 1ns/1ps
module sim_eth_tx_framer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_last = 1'b0;
    logic       wr_ready;
    logic [1:0] thr_sel = 2'd3;
    logic       no_fcs = 1'b0;
    logic       grant = 1'b1;
    logic       bit_en = 1'b1;
    logic       txd, tx_en, done, underrun;

    always #2 clk = ~clk;   // 250 MHz

    eth_tx_framer u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_last(wr_last), .wr_ready(wr_ready), .thr_sel(thr_sel),
        .no_fcs(no_fcs), .grant(grant), .bit_en(bit_en), .txd(txd),
        .tx_en(tx_en), .done(done), .underrun(underrun)
    );

    int   n_vec = 0;
    int   n_bad = 0;
    bit   cap[$];
    bit   exp_bits[$];
    byte unsigned body[$];
    int   n_done = 0;
    int   n_und = 0;
    bit   en_q = 1'b0;
    bit   slow = 1'b0;
    int   div = 0;
    bit   off_change = 1'b0;
    bit   prev_txd = 1'b0;

    always @(negedge clk) begin
        div    = (div + 1) % 3;
        bit_en = slow ? (div == 0) : 1'b1;
    end

    always @(posedge clk) en_q = bit_en;

    always @(negedge clk) begin
        if (!rst) begin
            if (en_q && tx_en) cap.push_back(txd);
            if (!en_q && (txd != prev_txd)) off_change = 1'b1;
            if (done) n_done++;
            if (underrun) n_und++;
        end
        prev_txd = txd;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input byte unsigned b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ 32'hEDB88320;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic push_byte_bits(input byte unsigned b);
        for (int i = 0; i < 8; i++) exp_bits.push_back(b[i]);
    endtask

    task automatic build_exp(input int nbody, input bit nofcs);
        logic [31:0] c;
        byte unsigned fr[$];
        exp_bits.delete();
        for (int i = 0; i < 7; i++) push_byte_bits(8'h55);
        push_byte_bits(8'hD5);
        for (int i = 0; i < nbody; i++) fr.push_back(body[i]);
        while (fr.size() < 60) fr.push_back(8'h00);
        c = '1;
        foreach (fr[i]) begin
            c = crc_byte(c, fr[i]);
            push_byte_bits(fr[i]);
        end
        if (!nofcs) begin
            c = ~c;
            for (int i = 0; i < 4; i++) push_byte_bits(c[8*i +: 8]);
        end
    endtask

    task automatic check_bits(input string req, input int upto);
        int bad_at;
        bad_at = -1;
        for (int i = 0; i < upto; i++) begin
            if (i >= cap.size() || i >= exp_bits.size()) begin
                bad_at = i;
                break;
            end
            if (cap[i] != exp_bits[i]) begin
                bad_at = i;
                break;
            end
        end
        chk(bad_at < 0, req, "first mismatching bit index", bad_at, -1);
    endtask

    task automatic check_frame(input string req, input int nbody, input bit nofcs);
        logic [31:0] c;
        byte unsigned b;
        build_exp(nbody, nofcs);
        chk(cap.size() == exp_bits.size(), req, "bit count", cap.size(), exp_bits.size());
        check_bits(req, exp_bits.size());
        if (!nofcs && cap.size() > 64 && (cap.size() % 8) == 0) begin
            c = '1;
            for (int k = 64; k < cap.size(); k += 8) begin
                for (int i = 0; i < 8; i++) b[i] = cap[k + i];
                c = crc_byte(c, b);
            end
            chk(c == 32'hDEBB20E3, "R4", "receiver CRC residue", c, 32'hDEBB20E3);
        end
    endtask

    task automatic make_body(input int n, input int seed);
        body.delete();
        for (int i = 0; i < n; i++) body.push_back(8'((seed + i * 37) ^ (i >> 3)));
    endtask

    task automatic put(input byte unsigned d, input bit last);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        wr_last  = last;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    task automatic put_range(input int from, input int to, input bit last_at_end);
        for (int i = from; i < to; i++) put(body[i], last_at_end && (i == to - 1));
    endtask

    task automatic clear_obs();
        cap.delete();
        n_done = 0;
        n_und = 0;
    endtask

    task automatic wait_end(input int lim);
        int t;
        t = 0;
        while (n_done == 0 && n_und == 0 && t < lim) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
    endtask

    // R12: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(tx_en == 1'b0, "R12", "tx_en in reset", tx_en, 0);
        chk(txd == 1'b0, "R12", "txd in reset", txd, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R12", "done after reset", done, 0);
        chk(wr_ready == 1'b1, "R12", "wr_ready after reset", wr_ready, 1);
    endtask

    // R1 R2 R3 R4 R5 R10: a complete frame
    task automatic t_frame(input string req, input int n, input int sel, input bit nofcs);
        clear_obs();
        thr_sel = 2'(sel);
        no_fcs  = nofcs;
        make_body(n, n * 3 + sel);
        put_range(0, n, 1'b1);
        wait_end(60000);
        check_frame(req, n, nofcs);
        check_bits("R1", 64);
        chk(n_done == 1, "R10", "done pulses", n_done, 1);
        chk(n_und == 0, "R8", "no underrun on full frame", n_und, 0);
        no_fcs = 1'b0;
    endtask

    // R6: early-start threshold
    task automatic t_thresh(input int sel, input int thr);
        clear_obs();
        thr_sel = 2'(sel);
        make_body(thr + 30, thr);
        put_range(0, thr - 1, 1'b0);
        repeat (60) @(negedge clk);
        chk(tx_en == 1'b0 && cap.size() == 0, "R6", "idle one byte below threshold",
            cap.size(), 0);
        put(body[thr - 1], 1'b0);
        repeat (40) @(negedge clk);
        chk(tx_en == 1'b1, "R6", "started at threshold", tx_en, 1);
        put_range(thr, thr + 30, 1'b1);
        wait_end(60000);
        check_frame("R6", thr + 30, 1'b0);
    endtask

    // R6: whole-frame mode waits for the last flag
    task automatic t_whole();
        clear_obs();
        thr_sel = 2'd3;
        make_body(201, 9);
        put_range(0, 200, 1'b0);
        repeat (2000) @(negedge clk);
        chk(tx_en == 1'b0 && cap.size() == 0, "R6", "whole mode holds without last",
            cap.size(), 0);
        put(body[200], 1'b1);
        wait_end(60000);
        check_frame("R6", 201, 1'b0);
    endtask

    // R7: grant gating
    task automatic t_grant();
        clear_obs();
        thr_sel = 2'd0;
        grant   = 1'b0;
        make_body(30, 77);
        put_range(0, 30, 1'b1);
        repeat (300) @(negedge clk);
        chk(tx_en == 1'b0 && cap.size() == 0, "R7", "no bits without grant", cap.size(), 0);
        grant = 1'b1;
        wait_end(60000);
        check_frame("R7", 30, 1'b0);
    endtask

    // R8: starvation abort and discard of the rest
    task automatic t_underrun();
        clear_obs();
        thr_sel = 2'd0;
        make_body(16, 5);
        put_range(0, 10, 1'b0);
        wait_end(20000);
        chk(n_und == 1, "R8", "underrun pulses", n_und, 1);
        chk(n_done == 0, "R8", "no done on abort", n_done, 0);
        chk(cap.size() == 144, "R8", "bits before stop", cap.size(), 144);
        build_exp(16, 1'b0);
        check_bits("R8", 144);
        put_range(10, 16, 1'b1);
        repeat (50) @(negedge clk);
        chk(tx_en == 1'b0, "R8", "rest of aborted frame not sent", tx_en, 0);
        t_frame("R8", 25, 0, 1'b0);
    endtask

    // R9: body length cut
    task automatic t_cap();
        clear_obs();
        thr_sel = 2'd3;
        make_body(1600, 11);
        put_range(0, 1600, 1'b1);
        wait_end(60000);
        check_frame("R9", 1514, 1'b0);
        chk(n_done == 1, "R9", "single frame for overlong body", n_done, 1);
    endtask

    // R11: strobe pacing
    task automatic t_slow();
        slow = 1'b1;
        off_change = 1'b0;
        t_frame("R11", 16, 3, 1'b0);
        chk(off_change == 1'b0, "R11", "txd change off strobe", off_change, 0);
        slow = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_frame("R3", 20, 3, 1'b0);
        t_frame("R2", 100, 0, 1'b0);
        t_frame("R5", 20, 3, 1'b1);
        t_frame("R5", 70, 0, 1'b1);
        t_thresh(0, 5);
        t_thresh(1, 381);
        t_thresh(2, 1021);
        t_whole();
        t_grant();
        t_underrun();
        t_cap();
        t_slow();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule